// File: doc/BRIEF.md
# Character-Row CRT Timing Generator

This block produces the raster timing for a character-based display. It advances by one character position on each enabled clock. It drives horizontal and vertical sync, a display-active strobe, a 14-bit character memory address and the scanline-within-row count. The frame is built from character lines. Lines are grouped into character rows of a programmable scanline height. After the last row, a programmable number of extra scanlines lengthens the frame, so the frame length does not have to be a whole number of rows.

The display-active window can be pushed 0, 1 or 2 characters later than the first character of each line, so that it lines up with a pipelined video fetch. A skew code of 3 blanks the display entirely. The timing registers come in as plain inputs and are expected to be held steady while the block runs. The memory address runs linearly across each line. At the start of every line it is reloaded from a row base. That row base steps by the displayed width from row to row and returns to the start address at the top of each frame.

Top module: `crt_char_timer`

## Requirements
- R1: While reset is asserted, and on the first enabled tick after it is released, hsync_o, vsync_o and disp_o are 0, and mem_addr_o and raster_o are 0.
- R2: While char_en is 0, no output changes.
- R3: A line lasts htotal_i+1 ticks. Within a line, mem_addr_o increases by 1 per tick, modulo 16384. On the first character of each line it takes the row base.
- R4: raster_o counts 0 to maxscan_i within each row, and is 0 on every extra scanline at the end of a frame.
- R5: A frame lasts ((vtotal_i+1)*(maxscan_i+1)+vadjust_i) lines. The vadjust_i extra lines follow the last row, and a value of 0 adds no line.
- R6: The row base equals start_addr_i on row 0 and grows by hdisp_i on each later row, so the first displayed address of a row is row base plus skew_i.
- R7: hsync_o rises on the tick whose character index equals hspos_i and stays high for hswidth_i ticks. A width of 0 produces no pulse.
- R8: vsync_o rises on the first character of scanline 0 of row vspos_i, never on an extra scanline, and stays high for vswidth_i lines. A width of 0 gives 16 lines.
- R9: For skew_i of 0 to 2, horizontal display is active for character indices skew_i to hdisp_i+skew_i-1. For skew_i of 3, disp_o stays 0.
- R10: Vertical display is active on rows 0 to vdisp_i-1, and disp_o is the AND of the horizontal and vertical windows.
- R11: After reset, disp_o stays 0 until the first frame boundary has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_en | input | 1 | Character tick enable |
| htotal_i | input | 8 | Last character index of a line |
| hdisp_i | input | 8 | Displayed characters per line |
| hspos_i | input | 8 | Character index where hsync starts |
| hswidth_i | input | 4 | Hsync width in ticks (0 = none) |
| vtotal_i | input | 7 | Last row index of a frame |
| vadjust_i | input | 5 | Extra scanlines after the last row |
| vdisp_i | input | 7 | Displayed rows per frame |
| vspos_i | input | 7 | Row where vsync starts |
| vswidth_i | input | 4 | Vsync width in lines (0 = 16) |
| maxscan_i | input | 5 | Last scanline index within a row |
| skew_i | input | 2 | Display delay in characters (3 = off) |
| start_addr_i | input | 14 | Address of the first row |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| disp_o | output | 1 | Display active |
| mem_addr_o | output | 14 | Character memory address |
| raster_o | output | 5 | Scanline within the row |

## Verification
Most internal errors change how long something lasts, so each test configuration measures a whole frame between two vsync rises. A miscounted extra scanline or row boundary changes the frame length by a full line of ticks. A wrong enable latch changes the active-character count of that same frame. A wrong row base shows up in the first displayed address seen after vsync, within one row. A stuck sync counter shows up in the pulse width on the very next pulse.

// File: rtl/crt_timer_pkg.sv
package crt_timer_pkg;

  // kind of vertical move taken at the end of a line
  typedef enum logic [2:0] {
    VMOVE_SCAN,
    VMOVE_ROW,
    VMOVE_PAD_ENTER,
    VMOVE_PAD_LINE,
    VMOVE_FRAME
  } vmove_e;

  localparam int unsigned SKEW_MAX = 2;

endpackage

// File: rtl/crt_hseq.sv
module crt_hseq #(
  parameter int unsigned HW = 8,
  parameter int unsigned SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic [HW-1:0] htotal,
  input  logic [HW-1:0] hdisp,
  input  logic [HW-1:0] hspos,
  input  logic [SW-1:0] hswidth,
  input  logic [1:0]    skew,
  output logic          line_end,
  output logic          hde,
  output logic          hsync
);
  import crt_timer_pkg::*;

  localparam int unsigned EW = HW + 1;

  logic [HW-1:0] hcnt_q, hcnt_d;
  logic          hde_q, hde_d;
  logic          hs_q, hs_d;
  logic [SW-1:0] hsc_q, hsc_d, hsc_inc;
  logic          win_open, win_close;

  always_comb begin
    line_end  = (hcnt_q == htotal);
    hcnt_d    = line_end ? '0 : hcnt_q + 1'b1;
    win_open  = (EW'(hcnt_d) == EW'(skew));
    win_close = (EW'(hcnt_d) == EW'(hdisp) + EW'(skew));

    hde_d = hde_q;
    if (32'(skew) > SKEW_MAX) begin
      hde_d = 1'b0;
    end else begin
      if (win_open)  hde_d = 1'b1;
      if (win_close) hde_d = 1'b0;
    end

    hsc_inc = hsc_q + 1'b1;
    hsc_d   = hsc_q;
    hs_d    = hs_q;
    if (hcnt_d == hspos) begin
      hsc_d = '0;
      hs_d  = (hswidth != '0);
    end else if (hs_q) begin
      hsc_d = hsc_inc;
      if (hsc_inc == hswidth) hs_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      hde_q  <= 1'b0;
      hs_q   <= 1'b0;
      hsc_q  <= '0;
    end else if (ce) begin
      hcnt_q <= hcnt_d;
      hde_q  <= hde_d;
      hs_q   <= hs_d;
      hsc_q  <= hsc_d;
    end
  end

  assign hde   = hde_q;
  assign hsync = hs_q;

  // R9: a skew code above the limit blanks the line on the next tick
  a_r9_skew_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && 32'(skew) > SKEW_MAX) |=> !hde_q);

  // R7: a zero width never raises hsync
  a_r7_zero_width: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && hswidth == '0 && !hs_q) |=> !hs_q);

endmodule

// File: rtl/crt_vseq.sv
module crt_vseq #(
  parameter int unsigned HW = 8,
  parameter int unsigned VW = 7,
  parameter int unsigned RW = 5,
  parameter int unsigned SW = 4,
  parameter int unsigned AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          line_end,
  input  logic [HW-1:0] hdisp,
  input  logic [VW-1:0] vtotal,
  input  logic [RW-1:0] vadjust,
  input  logic [VW-1:0] vdisp,
  input  logic [VW-1:0] vspos,
  input  logic [SW-1:0] vswidth,
  input  logic [RW-1:0] maxscan,
  input  logic [AW-1:0] start_addr,
  output logic [RW-1:0] raster,
  output logic          vde,
  output logic          vsync,
  output logic [AW-1:0] base_nx
);
  import crt_timer_pkg::*;

  logic [RW-1:0] raster_q, raster_d;
  logic [VW-1:0] row_q, row_d;
  logic [RW-1:0] pad_q, pad_d;
  logic          in_pad_q, in_pad_d;
  logic [AW-1:0] base_q, base_d;
  logic          vde_q, vde_d;
  logic          vs_q, vs_d;
  logic [SW-1:0] vsc_q, vsc_d, vsc_inc;
  logic          pad_done, row_chg;
  vmove_e        move;

  always_comb begin
    pad_done = ({1'b0, pad_q} + 1'b1) == {1'b0, vadjust};
    if (in_pad_q)               move = pad_done ? VMOVE_FRAME : VMOVE_PAD_LINE;
    else if (raster_q != maxscan) move = VMOVE_SCAN;
    else if (row_q != vtotal)   move = VMOVE_ROW;
    else if (vadjust == '0)     move = VMOVE_FRAME;
    else                        move = VMOVE_PAD_ENTER;

    raster_d = raster_q;
    row_d    = row_q;
    pad_d    = pad_q;
    in_pad_d = in_pad_q;
    base_d   = base_q;
    vde_d    = vde_q;
    vs_d     = vs_q;
    vsc_d    = vsc_q;
    vsc_inc  = vsc_q + 1'b1;
    row_chg  = 1'b0;

    if (line_end) begin
      raster_d = '0;
      unique case (move)
        VMOVE_SCAN: raster_d = raster_q + 1'b1;
        VMOVE_ROW: begin
          row_d   = row_q + 1'b1;
          base_d  = base_q + AW'(hdisp);
          row_chg = 1'b1;
        end
        VMOVE_PAD_ENTER: begin
          in_pad_d = 1'b1;
          pad_d    = '0;
          base_d   = start_addr;
        end
        VMOVE_PAD_LINE: pad_d = pad_q + 1'b1;
        VMOVE_FRAME: begin
          row_d    = '0;
          pad_d    = '0;
          in_pad_d = 1'b0;
          base_d   = start_addr;
          vde_d    = 1'b1;
          row_chg  = 1'b1;
        end
        default: raster_d = raster_q;
      endcase

      if (row_chg && row_d == vdisp) vde_d = 1'b0;

      if (row_chg && row_d == vspos) begin
        vs_d  = 1'b1;
        vsc_d = '0;
      end else if (vs_q) begin
        vsc_d = vsc_inc;
        if (vsc_inc == vswidth) vs_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raster_q <= '0;
      row_q    <= '0;
      pad_q    <= '0;
      in_pad_q <= 1'b0;
      base_q   <= '0;
      vde_q    <= 1'b0;
      vs_q     <= 1'b0;
      vsc_q    <= '0;
    end else if (ce) begin
      raster_q <= raster_d;
      row_q    <= row_d;
      pad_q    <= pad_d;
      in_pad_q <= in_pad_d;
      base_q   <= base_d;
      vde_q    <= vde_d;
      vs_q     <= vs_d;
      vsc_q    <= vsc_d;
    end
  end

  assign raster  = raster_q;
  assign vde     = vde_q;
  assign vsync   = vs_q;
  assign base_nx = base_d;

  // R4: extra scanlines always report scanline 0
  a_r4_pad_scan_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_pad_q |-> (raster_q == '0));

  // R8: vsync never begins inside the extra scanlines
  a_r8_no_start_in_pad: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vs_q) |-> !in_pad_q);

  // R5: the extra-line counter stays below the programmed count
  a_r5_pad_bound: assert property (@(posedge clk) disable iff (!rst_n)
    in_pad_q |-> (pad_q < vadjust));

endmodule

// File: rtl/crt_addr.sv
module crt_addr #(
  parameter int unsigned AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          line_end,
  input  logic [AW-1:0] base_nx,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = line_end ? base_nx : addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  addr_q <= '0;
    else if (ce) addr_q <= addr_d;
  end

  assign addr = addr_q;

  // R3: inside a line the address steps by one, wrapping at the top
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !line_end) |=> (addr_q == AW'($past(addr_q) + 1'b1)));

endmodule

// File: rtl/crt_char_timer.sv
module crt_char_timer #(
  parameter int unsigned HW = 8,
  parameter int unsigned VW = 7,
  parameter int unsigned RW = 5,
  parameter int unsigned SW = 4,
  parameter int unsigned AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          char_en,
  input  logic [HW-1:0] htotal_i,
  input  logic [HW-1:0] hdisp_i,
  input  logic [HW-1:0] hspos_i,
  input  logic [SW-1:0] hswidth_i,
  input  logic [VW-1:0] vtotal_i,
  input  logic [RW-1:0] vadjust_i,
  input  logic [VW-1:0] vdisp_i,
  input  logic [VW-1:0] vspos_i,
  input  logic [SW-1:0] vswidth_i,
  input  logic [RW-1:0] maxscan_i,
  input  logic [1:0]    skew_i,
  input  logic [AW-1:0] start_addr_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          disp_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [RW-1:0] raster_o
);

  logic rst_meta_q, rst_core_n;
  logic line_end, hde, vde;
  logic [AW-1:0] base_nx;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  crt_hseq #(.HW(HW), .SW(SW)) u_hseq (
    .clk(clk), .rst_n(rst_core_n), .ce(char_en),
    .htotal(htotal_i), .hdisp(hdisp_i), .hspos(hspos_i),
    .hswidth(hswidth_i), .skew(skew_i),
    .line_end(line_end), .hde(hde), .hsync(hsync_o)
  );

  crt_vseq #(.HW(HW), .VW(VW), .RW(RW), .SW(SW), .AW(AW)) u_vseq (
    .clk(clk), .rst_n(rst_core_n), .ce(char_en), .line_end(line_end),
    .hdisp(hdisp_i), .vtotal(vtotal_i), .vadjust(vadjust_i),
    .vdisp(vdisp_i), .vspos(vspos_i), .vswidth(vswidth_i),
    .maxscan(maxscan_i), .start_addr(start_addr_i),
    .raster(raster_o), .vde(vde), .vsync(vsync_o), .base_nx(base_nx)
  );

  crt_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_core_n), .ce(char_en), .line_end(line_end),
    .base_nx(base_nx), .addr(mem_addr_o)
  );

  assign disp_o = hde & vde;

  // R2: with the tick enable low every output holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !char_en |=> ($stable(mem_addr_o) && $stable(raster_o) &&
                  $stable(hsync_o) && $stable(vsync_o) && $stable(disp_o)));

  // R1: during reset the outputs are idle
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_core_n |-> (!hsync_o && !vsync_o && !disp_o && mem_addr_o == '0));

endmodule

// File: tb/crt_char_timer_bench.sv
module crt_char_timer_bench;

  typedef struct packed {
    logic [7:0]  ht, hd, hp;
    logic [3:0]  hw;
    logic [6:0]  vt;
    logic [4:0]  va;
    logic [6:0]  vd, vp;
    logic [3:0]  vw;
    logic [4:0]  ms;
    logic [1:0]  sk;
    logic [13:0] st;
    logic [15:0] e_cyc, e_de, e_hs, e_vs;
    logic [13:0] e_addr;
  } vec_t;

  // frame cycles = ((vt+1)*(ms+1)+va)*(ht+1); active = hd*vd*(ms+1) or 0;
  // hsync ticks = hw*lines; vsync ticks = vw_eff*(ht+1)
  localparam vec_t VECS [4] = '{
    '{8'd15, 8'd8, 8'd10, 4'd3, 7'd4, 5'd2, 7'd3, 7'd3, 4'd2, 5'd3, 2'd1, 14'h0100,
      16'd352, 16'd96, 16'd66, 16'd32, 14'h0101},
    '{8'd11, 8'd6, 8'd8, 4'd0, 7'd5, 5'd1, 7'd4, 7'd1, 4'd0, 5'd3, 2'd0, 14'h3FFE,
      16'd300, 16'd96, 16'd0, 16'd192, 14'h0004},
    '{8'd9, 8'd4, 8'd5, 4'd2, 7'd3, 5'd0, 7'd2, 7'd2, 4'd1, 5'd2, 2'd3, 14'h0040,
      16'd120, 16'd0, 16'd24, 16'd10, 14'h0000},
    '{8'd13, 8'd5, 8'd9, 4'd4, 7'd2, 5'd3, 7'd2, 7'd0, 4'd3, 5'd2, 2'd2, 14'h1234,
      16'd168, 16'd30, 16'd48, 16'd42, 14'h1236}
  };

  logic clk = 1'b0;
  logic rst_n, char_en;
  logic [7:0] htotal_i, hdisp_i, hspos_i;
  logic [3:0] hswidth_i, vswidth_i;
  logic [6:0] vtotal_i, vdisp_i, vspos_i;
  logic [4:0] vadjust_i, maxscan_i;
  logic [1:0] skew_i;
  logic [13:0] start_addr_i;
  logic hsync_o, vsync_o, disp_o;
  logic [13:0] mem_addr_o;
  logic [4:0] raster_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  crt_char_timer u_crt_char_timer (
    .clk(clk), .rst_n(rst_n), .char_en(char_en),
    .htotal_i(htotal_i), .hdisp_i(hdisp_i), .hspos_i(hspos_i),
    .hswidth_i(hswidth_i), .vtotal_i(vtotal_i), .vadjust_i(vadjust_i),
    .vdisp_i(vdisp_i), .vspos_i(vspos_i), .vswidth_i(vswidth_i),
    .maxscan_i(maxscan_i), .skew_i(skew_i), .start_addr_i(start_addr_i),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .disp_o(disp_o),
    .mem_addr_o(mem_addr_o), .raster_o(raster_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply_cfg(input vec_t c);
    htotal_i = c.ht; hdisp_i = c.hd; hspos_i = c.hp; hswidth_i = c.hw;
    vtotal_i = c.vt; vadjust_i = c.va; vdisp_i = c.vd; vspos_i = c.vp;
    vswidth_i = c.vw; maxscan_i = c.ms; skew_i = c.sk; start_addr_i = c.st;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; char_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; char_en = 1'b0;
    apply_cfg(VECS[0]);

    // table: one measured frame per configuration, between vsync rises 2 and 3
    for (int v = 0; v < 4; v++) begin
      int rises, cyc, de_n, hs_n, vs_n, maxr, faddr, guard;
      bit prev, got;
      apply_cfg(VECS[v]);
      do_reset();
      char_en = 1'b1;
      rises = 0; cyc = 0; de_n = 0; hs_n = 0; vs_n = 0; maxr = 0;
      faddr = 0; guard = 0; prev = 1'b0; got = 1'b0;
      while (rises < 3 && guard < 6000) begin
        @(negedge clk);
        guard++;
        if (vsync_o && !prev) rises++;
        prev = vsync_o;
        if (rises == 2) begin
          cyc++;
          if (disp_o) de_n++;
          if (hsync_o) hs_n++;
          if (vsync_o) vs_n++;
          if (int'(raster_o) > maxr) maxr = int'(raster_o);
          if (disp_o && !got) begin got = 1'b1; faddr = int'(mem_addr_o); end
        end
      end
      check(rises == 3, "R8 vsync recurs", rises, 3);
      check(cyc == int'(VECS[v].e_cyc), "R5 frame ticks", cyc, int'(VECS[v].e_cyc));
      check(de_n == int'(VECS[v].e_de), "R9 R10 active ticks", de_n, int'(VECS[v].e_de));
      check(hs_n == int'(VECS[v].e_hs), "R7 hsync ticks", hs_n, int'(VECS[v].e_hs));
      check(vs_n == int'(VECS[v].e_vs), "R8 vsync ticks", vs_n, int'(VECS[v].e_vs));
      check(maxr == int'(VECS[v].ms), "R4 top scanline", maxr, int'(VECS[v].ms));
      if (VECS[v].e_de != 0)
        check(faddr == int'(VECS[v].e_addr), "R6 first shown address", faddr, int'(VECS[v].e_addr));
    end

    // directed: reset state, first ticks, first frame blank
    begin
      int de_a, de_b;
      apply_cfg(VECS[0]);
      do_reset();
      check(!hsync_o && !vsync_o && !disp_o, "R1 idle syncs", int'({hsync_o, vsync_o, disp_o}), 0);
      check(mem_addr_o == 0 && raster_o == 0, "R1 idle counters", int'(mem_addr_o), 0);
      char_en = 1'b1;
      de_a = 0; de_b = 0;
      for (int i = 1; i <= 704; i++) begin
        @(negedge clk);
        if (i == 5) check(mem_addr_o == 14'd5, "R3 address step", int'(mem_addr_o), 5);
        if (i == 16) begin
          check(mem_addr_o == 14'd0, "R3 line reload", int'(mem_addr_o), 0);
          check(raster_o == 5'd1, "R4 next scanline", int'(raster_o), 1);
        end
        if (i <= 352) begin if (disp_o) de_a++; end
        else if (disp_o) de_b++;
      end
      check(de_a == 0, "R11 first frame blank", de_a, 0);
      check(de_b == 96, "R10 second frame active", de_b, 96);
    end

    // directed: enable low holds every output
    begin
      logic [13:0] a0; logic [4:0] r0; logic [2:0] s0;
      repeat (37) @(negedge clk);
      char_en = 1'b0;
      @(negedge clk);
      a0 = mem_addr_o; r0 = raster_o; s0 = {hsync_o, vsync_o, disp_o};
      repeat (6) @(negedge clk);
      check(mem_addr_o == a0, "R2 address held", int'(mem_addr_o), int'(a0));
      check(raster_o == r0 && {hsync_o, vsync_o, disp_o} == s0, "R2 others held",
            int'({raster_o, hsync_o, vsync_o, disp_o}), int'({r0, s0}));
    end

    // directed: reset in mid-run clears the outputs at once
    char_en = 1'b1;
    repeat (90) @(negedge clk);
    rst_n = 1'b0;
    #2;
    check(mem_addr_o == 0 && raster_o == 0 && !hsync_o && !vsync_o && !disp_o,
          "R1 reset mid-run", int'(mem_addr_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule